// File: doc/BRIEF.md
# Reference-Window Oscillator Frequency Counter

This block turns the frequency of a fast oscillator clock into a number. After a start request it opens a gate for a programmed number of reference-clock periods. While the gate is open, a counter running on the oscillator clock counts that clock's rising edges. When the gate closes, the frozen count is passed back to the reference domain and presented with a one-cycle valid strobe. The result approximates the window length times the ratio of oscillator frequency to reference frequency. A calibration engine can read this number as the window length times the instantaneous division ratio.

The two clocks are unrelated. The gate crosses into the oscillator domain as a level through a two-flop synchroniser. The counter clears itself on the rising edge of the synchronised gate and stops on its falling edge. On that falling edge it flips a toggle, which is synchronised back into the reference domain. The count bus is stable by then, so the reference side captures it directly.

The reference side is a four-state machine:
- ST_IDLE waits for `start`. On `start` it moves to ST_GATE and latches the window length.
- ST_GATE holds the gate high. When the window counter reaches zero it moves to ST_DRAIN.
- ST_DRAIN waits for the synchronised toggle event. On that event it captures the count and moves to ST_REPORT.
- ST_REPORT raises the valid strobe and returns to ST_IDLE.

Top module: `ref_window_counter`

## Requirements
- R1: After reset, `count_valid` is 0 and `count_out` is 0.
- R2: The gate stays open for exactly `win_len` reference periods. A `win_len` of 0 behaves exactly as a value of 1.
- R3: `count_out` is within ±3 counts of keff·f_osc/f_ref, where keff is the effective window length.
- R4: `count_valid` is high for exactly one reference cycle per measurement.
- R5: A `start` pulse that arrives while a measurement is in progress is ignored. It produces no extra measurement and does not alter the current one.
- R6: The oscillator counter starts from zero for every measurement. Counts never accumulate across measurements.
- R7: `win_len` is sampled only in the cycle in which `start` is accepted. Later changes do not alter the window in progress.
- R8: `count_out` changes only in the cycle in which `count_valid` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| ref_rst_n | input | 1 | Active-low reset for the reference domain |
| osc_clk | input | 1 | Oscillator (or prescaled oscillator) clock to be measured |
| osc_rst_n | input | 1 | Active-low reset for the oscillator domain |
| start | input | 1 | Request one measurement; accepted only when idle |
| win_len | input | 8 | Window length in reference periods; 0 is treated as 1 |
| count_out | output | 20 | Oscillator edges counted in the last window |
| count_valid | output | 1 | One-cycle strobe marking a new `count_out` |

## Verification
The bench uses a clock ratio of 10/3 and targets the following corner cases, each paired with the fault it would expose:
- A window length of zero. A design that treated zero literally would either hang in the gate state or wrap to a 256-period window, giving a count near 853 instead of about 3.
- A long window followed by a short one. A counter that was not cleared between measurements would report the sum of the two counts.
- Start pulses and a changed window length during a measurement. A design that failed to ignore them would produce a second strobe or a count scaled to the wrong window.
- The width of the strobe and the stability of the result afterwards. A design that got these wrong would show as a strobe wider than one cycle or as a result that drifts between strobes.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GATE,
        ST_DRAIN,
        ST_REPORT
    } rwc_state_t;
endpackage

// File: rtl/rwc_osc_counter.sv
module rwc_osc_counter #(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             osc_rst_n,
    input  logic             gate_async,
    output logic [CNT_W-1:0] edge_count,
    output logic             done_tgl
);
    logic [SYNC_STAGES-1:0] gate_sync;
    logic                   gate_s;
    logic                   gate_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge osc_clk or negedge osc_rst_n) begin
                if (!osc_rst_n) gate_sync <= '0;
                else            gate_sync <= gate_async;
            end
        end else begin : g_many
            always_ff @(posedge osc_clk or negedge osc_rst_n) begin
                if (!osc_rst_n) gate_sync <= '0;
                else            gate_sync <= {gate_sync[SYNC_STAGES-2:0], gate_async};
            end
        end
    endgenerate

    assign gate_s = gate_sync[SYNC_STAGES-1];

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) begin
            gate_prev  <= 1'b0;
            edge_count <= '0;
            done_tgl   <= 1'b0;
        end else begin
            gate_prev <= gate_s;
            if (gate_s && !gate_prev)
                edge_count <= '0;
            else if (gate_s)
                edge_count <= edge_count + 1'b1;
            if (!gate_s && gate_prev)
                done_tgl <= ~done_tgl;
        end
    end
endmodule

// File: rtl/rwc_toggle_sync.sv
module rwc_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic event_pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], tgl_in};
            last  <= chain[STAGES-1];
        end
    end

    assign event_pulse = chain[STAGES-1] ^ last;
endmodule

// File: rtl/rwc_window_fsm.sv
module rwc_window_fsm
    import rwc_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIN_W-1:0] win_len,
    input  logic             done_pulse,
    input  logic [CNT_W-1:0] osc_count,
    output logic             gate,
    output logic [CNT_W-1:0] count_out,
    output logic             count_valid,
    output logic             busy,
    output logic [WIN_W-1:0] win_eff
);
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    rwc_state_t       state, state_n;
    logic [WIN_W-1:0] win_cnt;
    logic [WIN_W-1:0] len_req;

    assign len_req = (win_len == '0) ? ONE : win_len;
    assign busy    = (state != ST_IDLE);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start)          state_n = ST_GATE;
            ST_GATE:   if (win_cnt == '0)  state_n = ST_DRAIN;
            ST_DRAIN:  if (done_pulse)     state_n = ST_REPORT;
            ST_REPORT:                     state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate        <= 1'b0;
            count_valid <= 1'b0;
            count_out   <= '0;
            win_cnt     <= '0;
            win_eff     <= ONE;
        end else begin
            gate        <= (state_n == ST_GATE);
            count_valid <= (state_n == ST_REPORT);
            if (state == ST_IDLE && start) begin
                win_eff <= len_req;
                win_cnt <= len_req - ONE;
            end else if (state == ST_GATE && win_cnt != '0) begin
                win_cnt <= win_cnt - ONE;
            end
            if (state == ST_DRAIN && done_pulse)
                count_out <= osc_count;
        end
    end
endmodule

// File: rtl/ref_window_counter.sv
module ref_window_counter #(
    parameter int WIN_W       = 8,
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             osc_clk,
    input  logic             osc_rst_n,
    input  logic             start,
    input  logic [WIN_W-1:0] win_len,
    output logic [CNT_W-1:0] count_out,
    output logic             count_valid
);
    logic             gate_ref;
    logic             busy;
    logic [WIN_W-1:0] win_eff;
    logic [CNT_W-1:0] osc_count;
    logic             done_tgl;
    logic             done_pulse;

    rwc_window_fsm #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_fsm (
        .clk         (ref_clk),
        .rst_n       (ref_rst_n),
        .start       (start),
        .win_len     (win_len),
        .done_pulse  (done_pulse),
        .osc_count   (osc_count),
        .gate        (gate_ref),
        .count_out   (count_out),
        .count_valid (count_valid),
        .busy        (busy),
        .win_eff     (win_eff)
    );

    rwc_osc_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_osc (
        .osc_clk    (osc_clk),
        .osc_rst_n  (osc_rst_n),
        .gate_async (gate_ref),
        .edge_count (osc_count),
        .done_tgl   (done_tgl)
    );

    rwc_toggle_sync #(.STAGES(SYNC_STAGES)) u_back (
        .clk         (ref_clk),
        .rst_n       (ref_rst_n),
        .tgl_in      (done_tgl),
        .event_pulse (done_pulse)
    );
endmodule

// File: rtl/rwc_check.sv
module rwc_check #(
    parameter int WIN_W = 8,
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate,
    input logic             busy,
    input logic             start,
    input logic [WIN_W-1:0] win_eff,
    input logic             valid,
    input logic [CNT_W-1:0] count
);
    logic           g_prev;
    logic [WIN_W:0] open_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_prev   <= 1'b0;
            open_len <= '0;
        end else begin
            g_prev   <= gate;
            open_len <= gate ? open_len + 1'b1 : '0;
        end
    end

    // R2: window length equals the latched effective length
    p_gate_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (g_prev && !gate) |-> (open_len == {1'b0, win_eff}));

    // R2: gate only open during a measurement
    p_gate_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> busy);

    // R4: strobe lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R5: start while busy never opens a new window
    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !$rose(gate));

    // R8: result only moves with the strobe
    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(count));
endmodule

bind ref_window_counter rwc_check #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
    .clk     (ref_clk),
    .rst_n   (ref_rst_n),
    .gate    (gate_ref),
    .busy    (busy),
    .start   (start),
    .win_eff (win_eff),
    .valid   (count_valid),
    .count   (count_out)
);

// File: tb/ref_window_counter_test.sv
`timescale 1ns/1ps
module ref_window_counter_test;
    localparam realtime REF_PERIOD = 10.0;
    localparam realtime OSC_PERIOD = 3.0;
    localparam int      TOL        = 3;

    logic        ref_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        ref_rst_n = 1'b0;
    logic        osc_rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  win_len = 8'd0;
    logic [19:0] count_out;
    logic        count_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(REF_PERIOD/2) ref_clk = ~ref_clk;
    always #(OSC_PERIOD/2) osc_clk = ~osc_clk;

    ref_window_counter uut (
        .ref_clk     (ref_clk),
        .ref_rst_n   (ref_rst_n),
        .osc_clk     (osc_clk),
        .osc_rst_n   (osc_rst_n),
        .start       (start),
        .win_len     (win_len),
        .count_out   (count_out),
        .count_valid (count_valid)
    );

    function automatic int expect_count(input int k);
        int keff = (k == 0) ? 1 : k;
        return (keff * 10 + 1) / 3;
    endfunction

    task automatic check(input string req, input string what, input bit ok,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input string what,
                              input int act, input int exp);
        check(req, what, (act >= exp - TOL) && (act <= exp + TOL), act, exp);
    endtask

    task automatic measure(input int k, output int result, output int pulses);
        @(negedge ref_clk);
        start   = 1'b1;
        win_len = 8'(k);
        @(negedge ref_clk);
        start  = 1'b0;
        result = -1;
        pulses = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge ref_clk);
            if (count_valid) begin
                result = int'(count_out);
                pulses = 1;
                break;
            end
        end
        @(negedge ref_clk);
        if (count_valid) pulses++;
    endtask

    task automatic t_reset;
        @(negedge ref_clk);
        check("R1", "valid after reset", count_valid == 1'b0, int'(count_valid), 0);
        check("R1", "count after reset", count_out == '0, int'(count_out), 0);
    endtask

    task automatic t_basic;
        int r, p;
        measure(64, r, p);
        check_near("R3", "k=64 count", r, expect_count(64));
        check("R4", "k=64 strobe width", p == 1, p, 1);
        measure(17, r, p);
        check_near("R3", "k=17 count", r, expect_count(17));
    endtask

    task automatic t_zero;
        int r0, r1, p;
        measure(0, r0, p);
        check_near("R2", "k=0 count", r0, expect_count(1));
        measure(1, r1, p);
        check_near("R2", "k=1 count", r1, expect_count(1));
        check("R2", "k=0 equals k=1", (r0 - r1 <= 1) && (r1 - r0 <= 1), r0, r1);
    endtask

    task automatic t_max;
        int r, p;
        measure(255, r, p);
        check_near("R3", "k=255 count", r, expect_count(255));
        check("R4", "k=255 strobe width", p == 1, p, 1);
    endtask

    task automatic t_clear;
        int r, p;
        measure(200, r, p);
        check_near("R6", "long window", r, expect_count(200));
        measure(4, r, p);
        check_near("R6", "short window after long", r, expect_count(4));
    endtask

    task automatic t_busy;
        int r = -1;
        int extra = 0;
        @(negedge ref_clk);
        start   = 1'b1;
        win_len = 8'd30;
        @(negedge ref_clk);
        start   = 1'b0;
        win_len = 8'd200;
        for (int i = 0; i < 10; i++) begin
            @(negedge ref_clk);
            start = (i % 2) == 0;
        end
        start = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge ref_clk);
            if (count_valid) begin
                r = int'(count_out);
                break;
            end
        end
        check_near("R7", "window keeps sampled length", r, expect_count(30));
        for (int i = 0; i < 400; i++) begin
            @(negedge ref_clk);
            if (count_valid) extra++;
        end
        check("R5", "no measurement from busy start", extra == 0, extra, 0);
    endtask

    task automatic t_hold;
        int r, p;
        int moved = 0;
        measure(40, r, p);
        win_len = 8'd9;
        for (int i = 0; i < 30; i++) begin
            @(negedge ref_clk);
            if (int'(count_out) != r) moved++;
        end
        check("R8", "result holds between strobes", moved == 0, moved, 0);
    endtask

    initial begin
        repeat (5) @(negedge ref_clk);
        ref_rst_n = 1'b1;
        osc_rst_n = 1'b1;
        t_reset();
        t_basic();
        t_zero();
        t_max();
        t_clear();
        t_busy();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge ref_clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule